// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Blocking Transmit

This block attaches a byte-wide asynchronous serial line (8 data bits, no parity, one stop bit, 115200 baud from a 50 MHz clock by default) to a processor's 32-bit valid/ready data bus. The bus side sees one word. Reading it takes the oldest received byte out of a 16-entry queue and marks the word as valid in bit 15. Writing it sends the low byte on the line.

No transmit queue exists. A write keeps the bus waiting until the whole character, stop bit included, has left the pin. Software gets flow control for free: a store that has completed means the line is idle again. The receiver resynchronises the incoming line, checks each start edge at mid-bit, then samples the data bits and the stop bit at their centres. Every offset in the 16-byte window decodes the same way.

Top module: `uart_mmio`

## Requirements
- R1: One bit time on both lines is CLK_HZ/BAUD clocks (434 with defaults). A frame is one start bit, 8 data bits and one stop bit.
- R2: A read while the queue holds data is acknowledged (ready high) in the same cycle valid is seen. It returns bit 15 = 1, the oldest byte in bits 7:0 and zero in all other bits, and it removes that byte.
- R3: A read while the queue is empty is acknowledged in the same cycle, returns bit 15 = 0, and leaves the queue unchanged.
- R4: A write loads bits 7:0 into the transmitter at once. Ready stays low until the stop bit has been driven for a full bit time, and then rises for one cycle.
- R5: The address input has no effect. Reads and writes behave the same at every offset from 0 to 15.
- R6: A low level on the receive line that is no longer low half a bit time after the falling edge is treated as noise and produces no byte.
- R7: Received bytes are returned in arrival order, and up to 16 bytes can wait unread.
- R8: A byte that completes while 16 bytes are already waiting is discarded, and the waiting bytes are unchanged.
- R9: The transmit pin idles high. Each frame starts low, sends data least significant bit first, and ends with a high stop bit.
- R10: A received frame whose stop bit samples low is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Bus request present |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Offset within the window (ignored) |
| wdata | input | 32 | Write data; bits 7:0 are sent |
| ready | output | 1 | Request completes in this cycle |
| rdata | output | 32 | Read word: bit 15 valid flag, bits 7:0 byte |
| rxPin | input | 1 | Serial receive line |
| txPin | output | 1 | Serial transmit line |

## Verification
The assertions assume that the master holds valid, we and wdata steady from the request until the cycle in which ready is high. They also assume that valid drops on the next cycle, so an acknowledged request is never seen twice. The bench drives every request at a falling clock edge, keeps it in place until it samples ready, and releases it right after the following rising edge. The assertions further assume that the receive line changes at most once per bit time apart from deliberate short pulses. The bench holds each serial bit for exactly one bit time and injects noise only as a pulse shorter than half a bit.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;

  typedef struct packed {
    logic txLoad;
    logic rxPop;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_SEND,
    BUS_ACK
  } busState_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

endpackage

// File: rtl/uart_mmio_ctrl.sv
module uart_mmio_ctrl
  import uart_mmio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         valid,
  input  logic         we,
  input  logic         txBusy,
  output logic         ready,
  output ctrlStrobes_t strobes
);

  busState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= BUS_IDLE;
    end else begin
      case (state)
        BUS_IDLE: if (valid && we) state <= BUS_SEND;
        BUS_SEND: if (!txBusy) state <= BUS_ACK;
        default:  state <= BUS_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.txLoad = (state == BUS_IDLE) && valid && we;
    strobes.rxPop  = (state == BUS_IDLE) && valid && !we;
    ready          = ((state == BUS_IDLE) && valid && !we) || (state == BUS_ACK);
  end

  // R4
  write_ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && we && ready) |-> !txBusy);

  // R4
  load_then_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txLoad |=> (!ready && txBusy));

endmodule

// File: rtl/uart_mmio_dp.sv
module uart_mmio_dp
  import uart_mmio_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int DEPTH  = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [7:0]   txByte,
  input  logic         rxPin,
  output logic         txPin,
  output logic         txBusy,
  output logic         rxHasData,
  output logic [7:0]   rxByte
);

  localparam int DIV   = CLK_HZ / BAUD;
  localparam int HALF  = DIV / 2;
  localparam int CNT_W = $clog2(DIV + 1);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] BIT_END  = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF - 1);

  // transmitter
  logic [9:0]       txShift;
  logic [CNT_W-1:0] txCnt;
  logic [3:0]       txBit;
  logic             txActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '1;
      txCnt    <= '0;
      txBit    <= '0;
      txActive <= 1'b0;
    end else if (strobes.txLoad) begin
      txShift  <= {1'b1, txByte, 1'b0};
      txCnt    <= '0;
      txBit    <= '0;
      txActive <= 1'b1;
    end else if (txActive) begin
      if (txCnt == BIT_END) begin
        txCnt   <= '0;
        txShift <= {1'b1, txShift[9:1]};
        if (txBit == 4'd9) txActive <= 1'b0;
        else               txBit    <= txBit + 4'd1;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  assign txPin  = txActive ? txShift[0] : 1'b1;
  assign txBusy = txActive;

  // receiver
  logic             rxMeta, rxSync;
  rxState_t         rxState;
  logic [CNT_W-1:0] rxCnt;
  logic [2:0]       rxBitIdx;
  logic [7:0]       rxShift;
  logic             pushReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxPin;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState  <= RX_IDLE;
      rxCnt    <= '0;
      rxBitIdx <= '0;
      rxShift  <= '0;
      pushReq  <= 1'b0;
    end else begin
      pushReq <= 1'b0;
      case (rxState)
        RX_IDLE: begin
          rxCnt <= '0;
          if (!rxSync) rxState <= RX_START;
        end
        RX_START: begin
          if (rxCnt == HALF_END) begin
            rxCnt    <= '0;
            rxBitIdx <= '0;
            rxState  <= rxSync ? RX_IDLE : RX_DATA;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (rxCnt == BIT_END) begin
            rxCnt   <= '0;
            rxShift <= {rxSync, rxShift[7:1]};
            if (rxBitIdx == 3'd7) rxState  <= RX_STOP;
            else                  rxBitIdx <= rxBitIdx + 3'd1;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        default: begin
          if (rxCnt == BIT_END) begin
            pushReq <= rxSync;
            rxState <= RX_IDLE;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // receive queue
  logic [7:0]   store [DEPTH];
  logic [PTR_W:0] wrPtr, rdPtr, fillLevel;
  logic fifoFull, fifoEmpty, doPush, doPop;

  assign fillLevel = wrPtr - rdPtr;
  assign fifoFull  = fillLevel == (PTR_W+1)'(DEPTH);
  assign fifoEmpty = wrPtr == rdPtr;
  assign doPush    = pushReq && !fifoFull;
  assign doPop     = strobes.rxPop && !fifoEmpty;

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr[PTR_W-1:0]] <= rxShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  assign rxHasData = !fifoEmpty;
  assign rxByte    = store[rdPtr[PTR_W-1:0]];

  // R8
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && fifoFull && !strobes.rxPop) |=> (fillLevel == (PTR_W+1)'(DEPTH)));

  // R6
  glitch_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_START && rxCnt == HALF_END && rxSync) |=> (rxState == RX_IDLE));

  // R10
  bad_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_STOP && rxCnt == BIT_END && !rxSync) |=> !pushReq);

  // R9
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> !txPin);

  // R9
  stop_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txActive) |-> $past(txPin));

endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
  import uart_mmio_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int DEPTH  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        valid,
  input  logic        we,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic        ready,
  output logic [31:0] rdata,
  input  logic        rxPin,
  output logic        txPin
);

  ctrlStrobes_t strobes;
  logic       txBusy, rxHasData;
  logic [7:0] rxByte;
  logic       unusedInputs;

  // R5: the offset takes no part in decoding
  assign unusedInputs = ^{addr, wdata[31:8]};

  uart_mmio_ctrl ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .valid   (valid),
    .we      (we),
    .txBusy  (txBusy),
    .ready   (ready),
    .strobes (strobes)
  );

  uart_mmio_dp #(
    .CLK_HZ (CLK_HZ),
    .BAUD   (BAUD),
    .DEPTH  (DEPTH)
  ) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .txByte    (wdata[7:0]),
    .rxPin     (rxPin),
    .txPin     (txPin),
    .txBusy    (txBusy),
    .rxHasData (rxHasData),
    .rxByte    (rxByte)
  );

  assign rdata = {16'h0000, rxHasData, 7'h00, rxByte};

endmodule

// File: tb/uart_mmio_test.sv
module uart_mmio_test;

  localparam int CLK_HZ = 1_600_000;
  localparam int BAUD   = 100_000;
  localparam int DIV    = CLK_HZ / BAUD;
  localparam int HALF   = DIV / 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ready;
  logic [31:0] rdata;
  logic        rxPin = 1'b1;
  logic        txPin;

  int total = 0;
  int bad = 0;

  uart_mmio #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(16)) uut (
    .clk(clk), .rstN(rstN), .valid(valid), .we(we), .addr(addr),
    .wdata(wdata), .ready(ready), .rdata(rdata), .rxPin(rxPin), .txPin(txPin)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] data);
    @(negedge clk);
    valid = 1'b1; we = 1'b0; addr = a;
    #1;
    check(ready === 1'b1, "R2/R3 read ready same cycle", {31'b0, ready}, 1);
    data = rdata;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic serialSend(input logic [7:0] b, input logic stopVal);
    @(negedge clk);
    rxPin = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxPin = b[i];
      repeat (DIV) @(negedge clk);
    end
    rxPin = stopVal;
    repeat (DIV) @(negedge clk);
    rxPin = 1'b1;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic expectByte(input logic [3:0] a, input logic [7:0] b, input string req);
    logic [31:0] d;
    busRead(a, d);
    check(d === {16'h0, 1'b1, 7'h0, b}, req, d, {16'h0, 1'b1, 7'h0, b});
  endtask

  task automatic expectEmpty(input logic [3:0] a, input string req);
    logic [31:0] d;
    busRead(a, d);
    check(d[15] === 1'b0, req, {31'b0, d[15]}, 0);
  endtask

  task automatic testReset;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txPin === 1'b1, "R9 idle high after reset", {31'b0, txPin}, 1);
    check(ready === 1'b0, "R4 no ready without valid", {31'b0, ready}, 0);
    expectEmpty(4'h0, "R3 empty after reset");
  endtask

  task automatic testSingleRx;
    serialSend(8'h5A, 1'b1);
    expectByte(4'h0, 8'h5A, "R1 R2 byte received");
    expectEmpty(4'h0, "R2 R3 byte removed after read");
  endtask

  task automatic testOrderAndOffsets;
    serialSend(8'h01, 1'b1);
    serialSend(8'hC3, 1'b1);
    serialSend(8'h80, 1'b1);
    expectByte(4'h7, 8'h01, "R5 R7 first at offset 7");
    expectByte(4'hF, 8'hC3, "R5 R7 second at offset 15");
    expectByte(4'h3, 8'h80, "R5 R7 third at offset 3");
    expectEmpty(4'hA, "R3 R5 empty at offset 10");
  endtask

  task automatic testOverflow;
    for (int i = 0; i < 17; i++) serialSend(8'(8'h20 + i), 1'b1);
    for (int i = 0; i < 16; i++) expectByte(4'h0, 8'(8'h20 + i), "R7 R8 kept bytes");
    expectEmpty(4'h0, "R8 seventeenth byte dropped");
  endtask

  task automatic testGlitch;
    @(negedge clk);
    rxPin = 1'b0;
    repeat (3) @(negedge clk);
    rxPin = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    expectEmpty(4'h0, "R6 short pulse ignored");
    serialSend(8'h77, 1'b1);
    expectByte(4'h0, 8'h77, "R6 receiver recovers after pulse");
  endtask

  task automatic testBadStop;
    serialSend(8'h3E, 1'b0);
    expectEmpty(4'h0, "R10 low stop bit discarded");
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] b);
    logic [9:0] seen;
    logic [9:0] frame;
    int k;
    int readyAt;
    frame = {1'b1, b, 1'b0};
    seen = '0;
    readyAt = -1;
    @(negedge clk);
    valid = 1'b1; we = 1'b1; addr = a; wdata = {24'hABCDEF, b};
    k = 0;
    while (readyAt < 0 && k < 20 * DIV) begin
      @(negedge clk);
      k++;
      #1;
      for (int bi = 0; bi < 10; bi++)
        if (k == HALF + bi * DIV) seen[bi] = txPin;
      if (ready) readyAt = k;
    end
    check(seen === frame, "R1 R9 transmitted frame", {22'b0, seen}, {22'b0, frame});
    check(readyAt == 10 * DIV + 2, "R4 ready after stop bit", readyAt, 10 * DIV + 2);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
    #1;
    check(ready === 1'b0, "R4 ready for one cycle only", {31'b0, ready}, 0);
    check(txPin === 1'b1, "R9 idle high after frame", {31'b0, txPin}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testSingleRx();
    testOrderAndOffsets();
    busWrite(4'h0, 8'hA5);
    busWrite(4'h4, 8'h3C);
    testGlitch();
    testBadStop();
    testOverflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule